// File: doc/BRIEF.md
# Device Power-Bit Keeper

This block stores a small group of power-control bits for each of several peripheral devices and drives them straight onto the device's power pins. Software programs the bits, a per-device timer-enable flag and a per-device reload value through a narrow index/data write bus. A 3-bit power-management mode input comes from the system power sequencer.

Each device has an inactivity timer built as a four-state machine: `TS_IDLE`, `TS_RUN`, `TS_FIRE` and `TS_SPENT`. The timer moves as follows:

- **load:** an activity strobe moves it from any state into `TS_RUN` and loads the reload value.
- **count:** in `TS_RUN`, each tick-enable pulse decrements the count.
- **expire:** in `TS_RUN`, a tick that arrives with the count at 1 or 0 moves it to `TS_FIRE`.
- **retire:** `TS_FIRE` always moves on to `TS_SPENT`, unless an activity strobe arrives in that cycle.
- **disable:** clearing the timer-enable flag returns the timer from any state to `TS_IDLE`.

While the timer is in `TS_FIRE`, it raises a one-cycle expiry pulse, and that pulse clears all of the device's control bits. A device whose timer is enabled also has its bits forced to zero while the mode is a low-power mode (Sleep, Suspend or Off). A device without an enabled timer keeps whatever software wrote, in every mode.

Top module: `devpwr_ctrl_mgr`

## Requirements
- R1: After reset, every control bit is 0, every expiry pulse is 0, every timer enable is 0 and every reload value is 0.
- R2: A write with index 0x50+d, when device d is not held, sets device d's four control bits to wr_data[3:0] at the next clock edge. pwr_bits[4d+3:4d] shows device d.
- R3: A write to index 0x41 sets device d's timer enable from wr_data[d]. A device whose enable is 0 never raises expire_pulse[d], whatever the activity or tick inputs do.
- R4: An activity strobe on an enabled device loads its reload value, written at index 0x60+d. After the Nth following tick edge (N = reload >= 1), expire_pulse[d] is 1 for the next cycle.
- R5: The expiry pulse is exactly one clock wide. It does not come again until a new activity strobe reloads the timer.
- R6: One edge after expire_pulse[d] is high, all four of device d's bits are 0. Other devices' bits are unchanged.
- R7: While device d is enabled and mode_i is 2 (Sleep), 3 (Suspend) or 4 (Off), device d's bits are 0 from the next edge onward. Writes to them are ignored.
- R8: A device with its timer disabled keeps its programmed bits in every mode. The encodings are 0 On, 1 Doze, 2 Sleep, 3 Suspend, 4 Off, and 5-7 act as On.
- R9: In modes 0 and 1, enabled devices accept writes. Leaving a low-power mode leaves the bits at 0 until they are rewritten.
- R10: An activity strobe during a count restarts it from the reload value. A reload value of 0 expires on the first tick.
- R11: When a write to device d's bits meets the cycle in which expire_pulse[d] is high, the clear wins.
- R12: Clearing a device's enable while its timer runs stops it with no pulse. From then on its bits follow R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Power-management mode |
| act_strb | input | NUM_DEV | Per-device activity strobe |
| tick_en | input | 1 | Prescaled timer tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 8 | Register index |
| wr_data | input | 8 | Register write data |
| pwr_bits | output | NUM_DEV*CB_W | Control bits, device d at [d*CB_W +: CB_W] |
| expire_pulse | output | NUM_DEV | Per-device one-cycle expiry pulse |

## Verification
The hardest situation to reach is a control-bit write that lands in the single cycle in which the expiry pulse is high. The bench gets there by loading a reload value of 0, strobing activity and giving one tick, which makes the pulse visible at a known falling edge. It then issues the write in that same cycle. A second hard case is clearing a timer's enable in the middle of a count, which is set up by writing index 0x41 between ticks. A long random phase then mixes modes, strobes, ticks and writes against the reference model on every clock.

// File: rtl/devpwr_pkg.sv
package devpwr_pkg;

    localparam int IDX_W = 8;

    localparam logic [IDX_W-1:0] IDX_TMR_EN      = 8'h41;
    localparam logic [IDX_W-1:0] IDX_CTRL_BASE   = 8'h50;
    localparam logic [IDX_W-1:0] IDX_RELOAD_BASE = 8'h60;

    typedef enum logic [2:0] {
        PM_ON      = 3'd0,
        PM_DOZE    = 3'd1,
        PM_SLEEP   = 3'd2,
        PM_SUSPEND = 3'd3,
        PM_OFF     = 3'd4
    } pm_mode_e;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_RUN,
        TS_FIRE,
        TS_SPENT
    } tmr_state_e;

    function automatic logic is_lowpwr(input logic [2:0] m);
        logic r;
        unique case (m)
            3'(PM_SLEEP), 3'(PM_SUSPEND), 3'(PM_OFF): r = 1'b1;
            default:                                  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/devpwr_regbank.sv
module devpwr_regbank
    import devpwr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int TMR_W   = 8,
    parameter int DATA_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_DEV-1:0]       tmr_en,
    output logic [NUM_DEV*TMR_W-1:0] reload_flat,
    output logic [NUM_DEV-1:0]       ctrl_wr
);

    logic en_hit;
    assign en_hit = wr_en && (wr_idx == IDX_TMR_EN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_en <= '0;
        end else if (en_hit) begin
            tmr_en <= wr_data[NUM_DEV-1:0];
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic rl_hit;
        assign rl_hit     = wr_en && (wr_idx == IDX_RELOAD_BASE + IDX_W'(d));
        assign ctrl_wr[d] = wr_en && (wr_idx == IDX_CTRL_BASE + IDX_W'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reload_flat[d*TMR_W +: TMR_W] <= '0;
            end else if (rl_hit) begin
                reload_flat[d*TMR_W +: TMR_W] <= wr_data[TMR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/devpwr_tmr_fsm.sv
module devpwr_tmr_fsm
    import devpwr_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             act_strb,
    input  logic             tick_en,
    input  logic [TMR_W-1:0] reload_val,
    output logic             expire
);

    tmr_state_e       state_q, state_d;
    logic [TMR_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!tmr_en) begin
            state_d = TS_IDLE;
            cnt_d   = '0;
        end else if (act_strb) begin
            state_d = TS_RUN;
            cnt_d   = reload_val;
        end else begin
            unique case (state_q)
                TS_IDLE: begin
                    state_d = TS_IDLE;
                end
                TS_RUN: begin
                    if (tick_en) begin
                        if (cnt_q <= TMR_W'(1)) begin
                            state_d = TS_FIRE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - TMR_W'(1);
                        end
                    end
                end
                TS_FIRE: begin
                    state_d = TS_SPENT;
                end
                TS_SPENT: begin
                    state_d = TS_SPENT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TS_FIRE: expire = tmr_en;
            default: expire = 1'b0;
        endcase
    end

endmodule

// File: rtl/devpwr_ctl_bits.sv
module devpwr_ctl_bits
    import devpwr_pkg::*;
#(
    parameter int CB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_en,
    input  logic [2:0]      mode_i,
    input  logic            wr_strb,
    input  logic [CB_W-1:0] wr_bits,
    input  logic            expire,
    output logic [CB_W-1:0] bits
);

    logic hold;
    assign hold = tmr_en && is_lowpwr(mode_i);

    // clear sources take priority over software writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (hold || expire) begin
            bits <= '0;
        end else if (wr_strb) begin
            bits <= wr_bits;
        end
    end

endmodule

// File: rtl/devpwr_ctrl_mgr.sv
module devpwr_ctrl_mgr
    import devpwr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int CB_W    = 4,
    parameter int TMR_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode_i,
    input  logic [NUM_DEV-1:0]      act_strb,
    input  logic                    tick_en,
    input  logic                    wr_en,
    input  logic [7:0]              wr_idx,
    input  logic [7:0]              wr_data,
    output logic [NUM_DEV*CB_W-1:0] pwr_bits,
    output logic [NUM_DEV-1:0]      expire_pulse
);

    localparam int DATA_W = 8;

    logic [NUM_DEV-1:0]       tmr_en;
    logic [NUM_DEV*TMR_W-1:0] reload_flat;
    logic [NUM_DEV-1:0]       ctrl_wr;

    devpwr_regbank #(
        .NUM_DEV (NUM_DEV),
        .TMR_W   (TMR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .tmr_en      (tmr_en),
        .reload_flat (reload_flat),
        .ctrl_wr     (ctrl_wr)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        devpwr_tmr_fsm #(
            .TMR_W (TMR_W)
        ) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_en     (tmr_en[d]),
            .act_strb   (act_strb[d]),
            .tick_en    (tick_en),
            .reload_val (reload_flat[d*TMR_W +: TMR_W]),
            .expire     (expire_pulse[d])
        );

        devpwr_ctl_bits #(
            .CB_W (CB_W)
        ) u_bits (
            .clk     (clk),
            .rst_n   (rst_n),
            .tmr_en  (tmr_en[d]),
            .mode_i  (mode_i),
            .wr_strb (ctrl_wr[d]),
            .wr_bits (wr_data[CB_W-1:0]),
            .expire  (expire_pulse[d]),
            .bits    (pwr_bits[d*CB_W +: CB_W])
        );
    end

endmodule

// File: rtl/devpwr_chk.sv
module devpwr_chk
    import devpwr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int CB_W    = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              mode_i,
    input logic                    wr_en,
    input logic [7:0]              wr_idx,
    input logic [NUM_DEV*CB_W-1:0] pwr_bits,
    input logic [NUM_DEV-1:0]      expire_pulse,
    input logic [NUM_DEV-1:0]      tmr_en
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (pwr_bits == '0 && expire_pulse == '0);
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        // R5
        one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire_pulse[d] |=> !expire_pulse[d]);

        // R6
        expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire_pulse[d] |=> (pwr_bits[d*CB_W +: CB_W] == '0));

        // R7
        lowpwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_en[d] && is_lowpwr(mode_i)) |=> (pwr_bits[d*CB_W +: CB_W] == '0));

        // R8
        free_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tmr_en[d] && !(wr_en && wr_idx == IDX_CTRL_BASE + 8'(d)))
            |=> $stable(pwr_bits[d*CB_W +: CB_W]));
    end

endmodule

bind devpwr_ctrl_mgr devpwr_chk #(
    .NUM_DEV (NUM_DEV),
    .CB_W    (CB_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .pwr_bits     (pwr_bits),
    .expire_pulse (expire_pulse),
    .tmr_en       (tmr_en)
);

// File: tb/test_devpwr_ctrl_mgr.sv
module test_devpwr_ctrl_mgr;

    localparam int CLK_PERIOD = 10;
    localparam int ND         = 4;
    localparam int CBW        = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_i = 3'd0;
    logic [ND-1:0]     act_strb = '0;
    logic              tick_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_idx = 8'h00;
    logic [7:0]        wr_data = 8'h00;
    logic [ND*CBW-1:0] pwr_bits;
    logic [ND-1:0]     expire_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [3:0] m_bits[ND];
    int         m_cnt[ND];
    int         m_reload[ND];
    bit         m_en[ND];
    bit         m_run[ND];
    bit         m_fire[ND];

    devpwr_ctrl_mgr #(.NUM_DEV(ND), .CB_W(CBW), .TMR_W(8)) i_devpwr_ctrl_mgr (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .act_strb(act_strb),
        .tick_en(tick_en), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pwr_bits(pwr_bits), .expire_pulse(expire_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int d = 0; d < ND; d++) begin
            m_bits[d] = 4'h0; m_cnt[d] = 0; m_reload[d] = 0;
            m_en[d] = 1'b0; m_run[d] = 1'b0; m_fire[d] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < ND; d++) begin
                m_bits[d] = 4'h0; m_cnt[d] = 0; m_reload[d] = 0;
                m_en[d] = 1'b0; m_run[d] = 1'b0; m_fire[d] = 1'b0;
            end
        end else begin
            for (int d = 0; d < ND; d++) begin
                bit low;
                bit pulse;
                low   = (mode_i == 3'd2) || (mode_i == 3'd3) || (mode_i == 3'd4);
                pulse = m_fire[d] && m_en[d];
                if ((m_en[d] && low) || pulse)
                    m_bits[d] = 4'h0;
                else if (wr_en && wr_idx == 8'h50 + 8'(d))
                    m_bits[d] = wr_data[3:0];
                if (!m_en[d]) begin
                    m_run[d] = 1'b0; m_fire[d] = 1'b0; m_cnt[d] = 0;
                end else if (act_strb[d]) begin
                    m_run[d] = 1'b1; m_fire[d] = 1'b0; m_cnt[d] = m_reload[d];
                end else if (m_fire[d]) begin
                    m_fire[d] = 1'b0;
                end else if (m_run[d] && tick_en) begin
                    if (m_cnt[d] <= 1) begin
                        m_fire[d] = 1'b1; m_run[d] = 1'b0; m_cnt[d] = 0;
                    end else begin
                        m_cnt[d] = m_cnt[d] - 1;
                    end
                end
                if (wr_en && wr_idx == 8'h41) m_en[d] = wr_data[d];
                if (wr_en && wr_idx == 8'h60 + 8'(d)) m_reload[d] = int'(wr_data);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            logic [ND*CBW-1:0] eb;
            logic [ND-1:0]     ep;
            for (int d = 0; d < ND; d++) begin
                eb[d*CBW +: CBW] = m_bits[d];
                ep[d]            = m_fire[d] && m_en[d];
            end
            chk(cur_req, 32'({ep, eb}), 32'({expire_pulse, pwr_bits}));
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
        wr_en = 1'b1; wr_idx = idx; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic act(input logic [ND-1:0] m);
        act_strb = m;
        @(negedge clk);
        act_strb = '0;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", 32'(pwr_bits), 32'h0);
        chk("R1", 32'(expire_pulse), 32'h0);
        rst_n = 1'b1;
        idle();
        cmp_on = 1'b1;

        // R2 plain writes
        cur_req = "R2";
        wr(8'h50, 8'hFA); wr(8'h51, 8'h05); wr(8'h52, 8'h0F); wr(8'h53, 8'h03);
        chk("R2", 32'(pwr_bits), 32'h3F5A);

        // R3 / R4 / R5 / R6 basic expiry
        cur_req = "R4";
        wr(8'h41, 8'h03);
        wr(8'h60, 8'd3);
        wr(8'h61, 8'd0);
        act(4'b0101);
        tick(); tick();
        chk("R4", 32'(expire_pulse), 32'h0);
        tick();
        chk("R4", 32'(expire_pulse), 32'h1);
        chk("R3", 32'(expire_pulse[2]), 32'h0);
        idle();
        chk("R5", 32'(expire_pulse), 32'h0);
        chk("R6", 32'(pwr_bits), 32'h3F50);
        tick(); tick();
        chk("R5", 32'(expire_pulse), 32'h0);

        // R7 / R8 / R9 mode holds
        cur_req = "R7";
        wr(8'h50, 8'h09); wr(8'h51, 8'h06);
        mode_i = 3'd2; idle();
        chk("R7", 32'(pwr_bits[7:0]), 32'h00);
        chk("R8", 32'(pwr_bits[15:8]), 32'h3F);
        mode_i = 3'd3;
        wr(8'h51, 8'h06);
        chk("R7", 32'(pwr_bits[7:4]), 32'h0);
        mode_i = 3'd4; idle();
        chk("R8", 32'(pwr_bits[15:8]), 32'h3F);
        cur_req = "R9";
        mode_i = 3'd1; idle();
        chk("R9", 32'(pwr_bits[3:0]), 32'h0);
        wr(8'h50, 8'h09);
        chk("R9", 32'(pwr_bits[3:0]), 32'h9);

        // R10 restart
        cur_req = "R10";
        mode_i = 3'd0;
        wr(8'h60, 8'd4);
        act(4'b0001);
        tick(); tick();
        act(4'b0001);
        tick(); tick(); tick();
        chk("R10", 32'(expire_pulse[0]), 32'h0);
        tick();
        chk("R10", 32'(expire_pulse[0]), 32'h1);
        idle();

        // R11 write meets expiry pulse; reload 0 expires on first tick
        cur_req = "R11";
        wr(8'h50, 8'h05);
        wr(8'h60, 8'd0);
        act(4'b0001);
        tick();
        chk("R10", 32'(expire_pulse[0]), 32'h1);
        wr(8'h50, 8'h0C);
        chk("R11", 32'(pwr_bits[3:0]), 32'h0);

        // R12 disable mid-count
        cur_req = "R12";
        wr(8'h51, 8'h07);
        wr(8'h61, 8'd5);
        act(4'b0010);
        tick(); tick();
        wr(8'h41, 8'h01);
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R12", 32'(expire_pulse[1]), 32'h0);
        end
        mode_i = 3'd2; idle();
        chk("R12", 32'(pwr_bits[7:4]), 32'h7);
        mode_i = 3'd0; idle();

        // random mix compared against the model
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel      = $urandom_range(0, 7);
            wr_en    = ($urandom_range(0, 3) == 0);
            wr_data  = 8'($urandom_range(0, 255));
            if (sel < 2)      wr_idx = 8'h41;
            else if (sel < 5) wr_idx = 8'h50 + 8'($urandom_range(0, ND - 1));
            else if (sel < 7) begin
                wr_idx  = 8'h60 + 8'($urandom_range(0, ND - 1));
                wr_data = 8'($urandom_range(0, 6));
            end else          wr_idx = 8'($urandom_range(0, 255));
            mode_i   = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : mode_i;
            tick_en  = ($urandom_range(0, 1) == 1);
            for (int d = 0; d < ND; d++) act_strb[d] = ($urandom_range(0, 9) == 0);
            @(negedge clk);
        end
        wr_en = 1'b0; tick_en = 1'b0; act_strb = '0;
        idle();

        summary();
        $finish;
    end

endmodule